// File: doc/BRIEF.md
# Audio Port Interrupt Aggregator

This block merges the FIFO-level requests of two audio ports into a single host interrupt line. Each port has a transmit and a receive direction, giving four request sources. A rising edge on a source request latches a sticky status bit. The line asserts when at least one latched bit is also set in both of two gating registers: an enable register and a mask register.

The host reaches the block through a small register port. Every write carries a bit mask, so the host can touch only chosen bits. On the status register a write can only clear bits. A fourth register holds reset controls that are active low: a global release bit, an interrupt re-arm bit and one release bit per port. Each control stays in effect while its bit reads 0 and ends when the host writes a 1. To acknowledge the line, the host drives the re-arm bit low and then high, and then services the FIFOs.

Top module: `aud_irq_agg`

## Requirements
- R1: Source i (0 = port A transmit, 1 = port A receive, 2 = port B transmit, 3 = port B receive) owns status, enable and mask bit 4*i, so the bits sit at 0, 4, 8 and 12. All other bits of these three registers read 0.
- R2: A rising edge on src_req[i] sets its status bit at the next clock edge. The bit stays set after the request drops. A request held high does not set the bit again once it has been cleared.
- R3: A write to the status register (address 0) clears each bit whose wmask bit is 1 and wdata bit is 0. Every other bit keeps its value, and no write can set a status bit.
- R4: A write to the enable register (address 1) or the mask register (address 2) replaces only the bits whose wmask bit is 1. Only source positions can be written.
- R5: irq_o is, one clock after the state it reflects, the OR of all status bits that are set in both enable and mask. A source set in only one of the two gating registers never drives irq_o.
- R6: While bit 4 of the soft-reset register (address 3) is 0, all status bits are cleared and held at 0, new edges are dropped and irq_o is low. Writing 1 to bit 4 re-arms the line.
- R7: While bit 8 (port A) or bit 12 (port B) of the soft-reset register is 0, the status bits of that port's two sources are cleared and held at 0. The other port's bits are not affected.
- R8: While bit 0 of the soft-reset register is 0, the status, enable and mask registers read 0, and writes to enable and mask are ignored.
- R9: In the soft-reset register only bits 0, 4, 8 and 12 are stored, and they read back as written. All other bits read 0.
- R10: If a source's rising edge and a status-clearing write arrive in the same cycle, the source's bit ends up set.
- R11: After rst_n, all four registers read 0 (every soft-reset control is active) and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| src_req | input | 4 | FIFO-level requests; index 0 A tx, 1 A rx, 2 B tx, 3 B rx |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 status, 1 enable, 2 mask, 3 soft reset |
| bus_wdata | input | 16 | Write data |
| bus_wmask | input | 16 | Per-bit write enable |
| bus_rdata | output | 16 | Read data of the register at bus_addr |
| irq_o | output | 1 | Host interrupt line, active high |

## Verification
The assertions check, on every cycle, that only source and control positions ever hold a 1 and that a status bit falls only after a status write or an active soft-reset control. They also check that irq_o follows the gated status one cycle later, and that an active global or re-arm control empties the registers by the next edge. Other behaviours need a scenario: an event captured at the same time as a clear, a held request that does not fire again, one port's reset leaving the other port's bits intact, and the exact cycle in which the line rises and falls. The directed scenarios in the bench show these.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    // Host register width
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_ENAB = 2'd1,
        SEL_MASK = 2'd2,
        SEL_SRST = 2'd3
    } reg_sel_e;

    // Replace only the bits selected by mask
    function automatic logic [REG_W-1:0] masked_update(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] data,
        input logic [REG_W-1:0] mask
    );
        return (cur & ~mask) | (data & mask);
    endfunction

    // A selected bit written 0 is cleared; nothing is ever set
    function automatic logic [REG_W-1:0] clear_only(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] data,
        input logic [REG_W-1:0] mask
    );
        return cur & (data | ~mask);
    endfunction

endpackage

// File: rtl/aud_irq_edge.sv
// Rising-edge detector for one request input
module aud_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = req;
        rise   = req & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/aud_irq_merge.sv
// Gates latched status with enable and mask, ORs and registers the line
module aud_irq_merge
    import aud_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic [REG_W-1:0] stat,
    input  logic [REG_W-1:0] enab,
    input  logic [REG_W-1:0] mask,
    output logic             irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = armed & (|(stat & enab & mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
    import aud_irq_pkg::*;
#(
    parameter int N_PORTS    = 2,
    parameter int SRC_STRIDE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*N_PORTS-1:0] src_req,
    input  logic                 bus_we,
    input  logic [1:0]           bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [REG_W-1:0]     bus_wmask,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 irq_o
);
    localparam int N_SRC   = 2 * N_PORTS;
    localparam int GLB_BIT = 0;
    localparam int IRR_BIT = SRC_STRIDE;

    function automatic int port_bit(input int p);
        return SRC_STRIDE * (2 + p);
    endfunction

    function automatic logic [REG_W-1:0] make_src_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_SRC; i++) m[i*SRC_STRIDE] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] make_rst_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[GLB_BIT] = 1'b1;
        m[IRR_BIT] = 1'b1;
        for (int p = 0; p < N_PORTS; p++) m[port_bit(p)] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] SRC_MASK = make_src_mask();
    localparam logic [REG_W-1:0] RST_MASK = make_rst_mask();

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] enab;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] srst;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_SRC-1:0] rise;
    logic [REG_W-1:0] rise_pos;
    logic [REG_W-1:0] port_hold;
    logic [REG_W-1:0] stat_keep;
    logic             glb_rel;
    logic             irr_rel;
    logic             wr_stat, wr_enab, wr_mask, wr_srst;

    // One edge detector per source
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        aud_irq_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (src_req[g]),
            .rise (rise[g])
        );
    end

    // Place edges and port holds at their register positions
    always_comb begin
        rise_pos  = '0;
        port_hold = '0;
        for (int i = 0; i < N_SRC; i++) begin
            rise_pos[i*SRC_STRIDE]  = rise[i];
            port_hold[i*SRC_STRIDE] = ~r_q.srst[port_bit(i / 2)];
        end
    end

    always_comb begin
        wr_stat = bus_we && (bus_addr == SEL_STAT);
        wr_enab = bus_we && (bus_addr == SEL_ENAB);
        wr_mask = bus_we && (bus_addr == SEL_MASK);
        wr_srst = bus_we && (bus_addr == SEL_SRST);
        glb_rel = r_q.srst[GLB_BIT];
        irr_rel = r_q.srst[IRR_BIT];

        stat_keep = wr_stat ? clear_only(r_q.stat, bus_wdata, bus_wmask) : r_q.stat;

        r_d = r_q;
        if (wr_srst)
            r_d.srst = masked_update(r_q.srst, bus_wdata, bus_wmask) & RST_MASK;

        if (!glb_rel) begin
            r_d.stat = '0;
            r_d.enab = '0;
            r_d.mask = '0;
        end else begin
            if (wr_enab)
                r_d.enab = masked_update(r_q.enab, bus_wdata, bus_wmask) & SRC_MASK;
            if (wr_mask)
                r_d.mask = masked_update(r_q.mask, bus_wdata, bus_wmask) & SRC_MASK;
            if (!irr_rel)
                r_d.stat = '0;
            else
                r_d.stat = (stat_keep | rise_pos) & ~port_hold & SRC_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr)
            SEL_STAT: bus_rdata = r_q.stat;
            SEL_ENAB: bus_rdata = r_q.enab;
            SEL_MASK: bus_rdata = r_q.mask;
            default:  bus_rdata = r_q.srst;
        endcase
    end

    aud_irq_merge u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .armed(glb_rel & irr_rel),
        .stat (r_q.stat),
        .enab (r_q.enab),
        .mask (r_q.mask),
        .irq  (irq_o)
    );
endmodule

// File: rtl/aud_irq_agg_chk.sv
module aud_irq_agg_chk
    import aud_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] SRC_MASK = '0,
    parameter logic [REG_W-1:0] RST_MASK = '0,
    parameter int               GLB_BIT  = 0,
    parameter int               IRR_BIT  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [REG_W-1:0] st,
    input logic [REG_W-1:0] en,
    input logic [REG_W-1:0] mk,
    input logic [REG_W-1:0] srst,
    input logic             irq_o
);
    assert_src_positions_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st | en | mk) & ~SRC_MASK) == '0);

    assert_stat_drop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(st) & ~st)) |->
            ($past(bus_we && bus_addr == 2'd0) || ($past(srst) != RST_MASK)));

    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(srst[GLB_BIT] && srst[IRR_BIT] && (|(st & en & mk)))));

    assert_rearm_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !srst[IRR_BIT] |=> (st == '0 && !irq_o));

    assert_global_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !srst[GLB_BIT] |=> (st == '0 && en == '0 && mk == '0));

    assert_srst_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst & ~RST_MASK) == '0);
endmodule

bind aud_irq_agg aud_irq_agg_chk #(
    .SRC_MASK(SRC_MASK),
    .RST_MASK(RST_MASK),
    .GLB_BIT (GLB_BIT),
    .IRR_BIT (IRR_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .st      (r_q.stat),
    .en      (r_q.enab),
    .mk      (r_q.mask),
    .srst    (r_q.srst),
    .irq_o   (irq_o)
);

// File: tb/sim_aud_irq_agg.sv
module sim_aud_irq_agg;
    import aud_irq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       src_req = '0;
    logic             bus_we = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [REG_W-1:0] bus_wdata = '0;
    logic [REG_W-1:0] bus_wmask = '0;
    logic [REG_W-1:0] bus_rdata;
    logic             irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aud_irq_agg u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wmask(bus_wmask),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    task automatic chk(input string tag, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d, input logic [REG_W-1:0] m);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wmask = m;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [REG_W-1:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_is(input string tag, input logic exp);
        chk(tag, {15'd0, irq_o}, {15'd0, exp});
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); src_req[idx] = 1'b1;
        @(negedge clk); src_req[idx] = 1'b0;
    endtask

    task automatic t_reset_state();
        rd("R11 status", SEL_STAT, 16'h0000);
        rd("R11 enable", SEL_ENAB, 16'h0000);
        rd("R11 mask",   SEL_MASK, 16'h0000);
        rd("R11 srst",   SEL_SRST, 16'h0000);
        irq_is("R11 irq", 1'b0);
    endtask

    task automatic t_release();
        wr(SEL_SRST, 16'hFFFF, 16'hFFFF);
        rd("R9 only control bits", SEL_SRST, 16'h1111);
        wr(SEL_SRST, 16'h0000, 16'h0010);
        rd("R9 masked write", SEL_SRST, 16'h1101);
        wr(SEL_SRST, 16'h0010, 16'h0010);
        rd("R9 restore", SEL_SRST, 16'h1111);
    endtask

    task automatic t_capture();
        logic [REG_W-1:0] exp = '0;
        for (int i = 0; i < 4; i++) begin
            pulse(i);
            exp[4*i] = 1'b1;
            rd("R1 R2 sticky position", SEL_STAT, exp);
        end
        irq_is("R5 no enable no irq", 1'b0);
        wr(SEL_STAT, 16'h0000, 16'hFFFF);
        rd("R3 clear all", SEL_STAT, 16'h0000);
    endtask

    task automatic t_gating();
        wr(SEL_ENAB, 16'hFFFF, 16'h0100);
        rd("R4 masked enable", SEL_ENAB, 16'h0100);
        wr(SEL_MASK, 16'h0100, 16'h0100);
        rd("R4 masked mask", SEL_MASK, 16'h0100);
        pulse(2);
        rd("R2 set", SEL_STAT, 16'h0100);
        irq_is("R5 one cycle later", 1'b0);
        @(negedge clk);
        irq_is("R5 asserted", 1'b1);
        wr(SEL_STAT, 16'h0000, 16'h0100);
        rd("R3 selective clear", SEL_STAT, 16'h0000);
        irq_is("R5 falls one cycle later", 1'b1);
        @(negedge clk);
        irq_is("R5 deasserted", 1'b0);
        wr(SEL_MASK, 16'h0001, 16'h0001);
        pulse(0);
        @(negedge clk);
        irq_is("R5 mask without enable", 1'b0);
        wr(SEL_STAT, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_write_rules();
        wr(SEL_STAT, 16'hFFFF, 16'hFFFF);
        rd("R3 write cannot set", SEL_STAT, 16'h0000);
        pulse(1);
        pulse(3);
        wr(SEL_STAT, 16'h0000, 16'h1000);
        rd("R3 unselected kept", SEL_STAT, 16'h0010);
        wr(SEL_STAT, 16'h0010, 16'h0010);
        rd("R3 one written keeps", SEL_STAT, 16'h0010);
        wr(SEL_STAT, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_level();
        @(negedge clk); src_req[0] = 1'b1;
        @(negedge clk);
        rd("R2 level sets once", SEL_STAT, 16'h0001);
        wr(SEL_STAT, 16'h0000, 16'h0001);
        repeat (3) @(negedge clk);
        rd("R2 held request no refire", SEL_STAT, 16'h0000);
        src_req[0] = 1'b0;
    endtask

    task automatic t_race();
        pulse(0);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = SEL_STAT; bus_wdata = 16'h0000; bus_wmask = 16'hFFFF;
        src_req[3] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; src_req[3] = 1'b0;
        rd("R10 edge beats clear", SEL_STAT, 16'h1000);
        wr(SEL_STAT, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_rearm();
        wr(SEL_ENAB, 16'hFFFF, 16'hFFFF);
        rd("R4 enable only sources", SEL_ENAB, 16'h1111);
        wr(SEL_MASK, 16'hFFFF, 16'hFFFF);
        pulse(1);
        @(negedge clk);
        irq_is("R5 irq up", 1'b1);
        wr(SEL_SRST, 16'h0000, 16'h0010);
        @(negedge clk);
        rd("R6 status cleared", SEL_STAT, 16'h0000);
        irq_is("R6 irq low", 1'b0);
        pulse(2);
        @(negedge clk);
        rd("R6 edge dropped", SEL_STAT, 16'h0000);
        irq_is("R6 irq stays low", 1'b0);
        wr(SEL_SRST, 16'h0010, 16'h0010);
        pulse(2);
        rd("R6 re-armed", SEL_STAT, 16'h0100);
        @(negedge clk);
        irq_is("R6 irq again", 1'b1);
        wr(SEL_STAT, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_ports();
        for (int i = 0; i < 4; i++) pulse(i);
        rd("R7 all set", SEL_STAT, 16'h1111);
        wr(SEL_SRST, 16'h0000, 16'h0100);
        @(negedge clk);
        rd("R7 port A cleared only", SEL_STAT, 16'h1100);
        pulse(0);
        rd("R7 port A held", SEL_STAT, 16'h1100);
        wr(SEL_SRST, 16'h0100, 16'h0100);
        pulse(1);
        rd("R7 port A released", SEL_STAT, 16'h1110);
        wr(SEL_SRST, 16'h0000, 16'h1000);
        @(negedge clk);
        rd("R7 port B cleared only", SEL_STAT, 16'h0010);
        wr(SEL_SRST, 16'h1000, 16'h1000);
        wr(SEL_STAT, 16'h0000, 16'hFFFF);
    endtask

    task automatic t_global();
        pulse(0);
        rd("R8 precondition", SEL_STAT, 16'h0001);
        wr(SEL_SRST, 16'h0000, 16'h0001);
        @(negedge clk);
        rd("R8 status zero", SEL_STAT, 16'h0000);
        rd("R8 enable zero", SEL_ENAB, 16'h0000);
        rd("R8 mask zero",   SEL_MASK, 16'h0000);
        irq_is("R8 irq low", 1'b0);
        wr(SEL_ENAB, 16'hFFFF, 16'hFFFF);
        rd("R8 enable write ignored", SEL_ENAB, 16'h0000);
        wr(SEL_SRST, 16'h0001, 16'h0001);
        rd("R8 still zero after release", SEL_ENAB, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_release();
        t_capture();
        t_gating();
        t_write_rules();
        t_level();
        t_race();
        t_rearm();
        t_ports();
        t_global();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule